// File: doc/BRIEF.md
# Reset and Watchdog Supervisor

This block produces the one active-low reset that holds a small microcontroller core. Four sources can assert it. A power-up hold keeps the core in reset for a fixed number of clocks after the supply becomes good. The external reset pin is filtered so that short glitches are ignored. A low-voltage flag forces reset within two clocks. A watchdog has no enable and no disable control. It bites when the core stops sending refresh strobes, and the bite holds the core in reset for a fixed pulse length.

The core leaves reset on a clock edge, and only once every source has gone quiet. A sticky cause register shows which sources have asserted reset since the core last read it. The block also presents the constant restart address that the core loads when it leaves reset. The external pin may be tied high; the power-up hold alone then gives a valid reset. All intervals are counted in clock cycles and set by parameters, so a fast test can use short values. `supply_ok` is the synchronous active-low reset of the block itself.

Top module: `reset_supervisor`

## Requirements
- R1: While `supply_ok` is low on a clock edge, `sys_rst_n` is 0 after that edge and `reset_cause` is 4'b0001.
- R2: Count the first edge that samples `supply_ok` high as edge 1, with no other source active. `sys_rst_n` stays 0 through edge POR_CYCLES and becomes 1 after edge POR_CYCLES+1.
- R3: `ext_rst_n` passes through SYNC_STAGES flops. If it is sampled low on PIN_MIN_LOW consecutive edges, reset is accepted. Count the first low sample as edge 1: `sys_rst_n` is still 1 after edge PIN_MIN_LOW+SYNC_STAGES and is 0 after edge PIN_MIN_LOW+SYNC_STAGES+1.
- R4: A low run on `ext_rst_n` of fewer than PIN_MIN_LOW samples, or a pin that stays high, leaves `sys_rst_n` at 1 and sets no cause bit.
- R5: Count the first edge that samples `ext_rst_n` high after an accepted reset as edge 1, with no other source active. `sys_rst_n` is still 0 after edge SYNC_STAGES+1 and is 1 after edge SYNC_STAGES+2.
- R6: Count the edge that samples `lowv_flag` high as edge 1. `sys_rst_n` is 0 after edge 2 and stays 0 while the flag is high. It is 1 again two edges after the flag is sampled low, if nothing else holds reset.
- R7: The watchdog has no disable. While the core runs, WDT_CYCLES consecutive edges with `wd_kick` low make the next edge drive `sys_rst_n` to 0. A kick at most WDT_CYCLES edges after the previous kick prevents this.
- R8: A watchdog bite holds `sys_rst_n` at 0 for exactly WDT_PULSE cycles, then releases it.
- R9: `reset_cause` bit 0 means power-up, bit 1 the pin, bit 2 low voltage and bit 3 the watchdog. A bit is set while its source asserts reset. An edge with `cause_rd` high clears every bit whose source is idle on that edge.
- R10: `boot_addr` always equals BOOT_ADDR, 16'h000C by default.
- R11: When sources overlap, `sys_rst_n` rises only after the last active source has deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| supply_ok | input | 1 | Supply good; low holds the whole block in its power-down state |
| lowv_flag | input | 1 | Low-voltage detect, high means the supply is too low |
| wd_kick | input | 1 | Watchdog refresh strobe from the core |
| cause_rd | input | 1 | Core read strobe for the cause register; clears it |
| sys_rst_n | output | 1 | Internal reset to the core, active low |
| reset_cause | output | 4 | Sticky record of the reset sources |
| boot_addr | output | ADDR_W | Restart address loaded by the core on release |

## Verification
The hardest state to reach from the ports is a watchdog bite at exactly its limit. The counter runs only after the power-up hold has finished, and any refresh restarts it. The stimulus therefore first runs long stretches in which refreshes arrive at random gaps up to the limit. It then stops refreshing, gives one refresh exactly WDT_CYCLES edges after the previous one, and only then lets the count expire. This checks the edge on either side of the bite. Random pin glitches one sample shorter than the acceptance length run alongside the random refreshes. An overlap of a low-voltage event and a pin reset then checks that release waits for the last source.

// File: rtl/rst_sup_pkg.sv
// Shared definitions for the reset supervisor: cause bit positions and the
// cause vector type. Assumes the core decodes the cause bits at these fixed
// positions.
package rst_sup_pkg;
    localparam int unsigned CAUSE_W    = 4;
    localparam int unsigned CAUSE_POR  = 0;
    localparam int unsigned CAUSE_PIN  = 1;
    localparam int unsigned CAUSE_LOWV = 2;
    localparam int unsigned CAUSE_WDOG = 3;

    typedef logic [CAUSE_W-1:0] cause_vec_t;

    // Build a cause vector from the individual source flags.
    function automatic cause_vec_t pack_cause(input logic por, input logic pin,
                                              input logic lowv, input logic wdog);
        cause_vec_t v;
        v             = '0;
        v[CAUSE_POR]  = por;
        v[CAUSE_PIN]  = pin;
        v[CAUSE_LOWV] = lowv;
        v[CAUSE_WDOG] = wdog;
        return v;
    endfunction
endpackage

// File: rtl/rst_por_delay.sv
// Power-up hold timer. Counts clocks from the moment supply_ok is seen high
// and raises done after DELAY edges. Assumes rst_n is the supply-good level
// and is sampled synchronously.
module rst_por_delay #(
    parameter int unsigned DELAY = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(DELAY + 1);

    logic [CNT_W-1:0] elapsed;

    assign done = (elapsed == CNT_W'(DELAY));

    // Count up once per clock until the hold time has passed, then stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            elapsed <= '0;
        else if (!done)
            elapsed <= elapsed + 1'b1;
    end
endmodule

// File: rtl/rst_pin_filter.sv
// External reset pin filter. Passes the asynchronous pin through a flop chain
// and accepts a reset only after MIN_LOW consecutive low samples. Assumes the
// pin is active low and may glitch freely.
module rst_pin_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_LOW     = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic accept
);
    localparam int unsigned CNT_W = $clog2(MIN_LOW + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [SYNC_STAGES:0]   sync_next;
    logic                   pin_sync_n;
    logic [CNT_W-1:0]       low_run;

    assign sync_next  = {sync_q, pin_n};
    assign pin_sync_n = sync_q[SYNC_STAGES-1];
    assign accept     = (low_run == CNT_W'(MIN_LOW));

    // Move the pin level one stage along the flop chain each clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '1;
        else
            sync_q <= sync_next[SYNC_STAGES-1:0];
    end

    // Count consecutive low samples, saturating at the acceptance length.
    always_ff @(posedge clk) begin
        if (!rst_n || pin_sync_n)
            low_run <= '0;
        else if (!accept)
            low_run <= low_run + 1'b1;
    end

    // R3
    accept_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accept) |-> ($past(pin_n, SYNC_STAGES + 1) == 1'b0));
endmodule

// File: rtl/rst_watchdog.sv
// Watchdog with no disable control. While the core runs, it counts clocks
// since the last refresh strobe and starts a bite pulse of PULSE clocks
// after TIMEOUT unrefreshed edges. Assumes src_hold is high while any other
// reset source is active, and core_in_reset mirrors the internal reset.
module rst_watchdog #(
    parameter int unsigned TIMEOUT = 600000,
    parameter int unsigned PULSE   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_hold,
    input  logic core_in_reset,
    input  logic kick,
    output logic bite
);
    localparam int unsigned T_W = $clog2(TIMEOUT + 1);
    localparam int unsigned P_W = $clog2(PULSE + 1);

    logic [T_W-1:0] idle_cnt;
    logic [P_W-1:0] pulse_cnt;

    // Run the refresh timeout, then time the bite pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || src_hold) begin
            idle_cnt  <= '0;
            pulse_cnt <= '0;
            bite      <= 1'b0;
        end else if (bite) begin
            if (pulse_cnt == P_W'(PULSE - 1)) begin
                bite      <= 1'b0;
                pulse_cnt <= '0;
            end else begin
                pulse_cnt <= pulse_cnt + 1'b1;
            end
        end else if (core_in_reset || kick) begin
            idle_cnt <= '0;
        end else if (idle_cnt == T_W'(TIMEOUT - 1)) begin
            bite      <= 1'b1;
            pulse_cnt <= '0;
            idle_cnt  <= '0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R7
    no_bite_after_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bite) |-> !$past(kick));
endmodule

// File: rtl/rst_cause_log.sv
// Sticky reset-cause register. Each bit is set while its source asserts
// reset. A read strobe replaces the register with the sources active on that
// edge. Assumes the core reads it only while it is running.
module rst_cause_log (
    input  logic                    clk,
    input  logic                    rst_n,
    input  rst_sup_pkg::cause_vec_t set_vec,
    input  logic                    rd,
    output rst_sup_pkg::cause_vec_t cause
);
    import rst_sup_pkg::*;

    // Accumulate active sources; a read drops the ones that have gone idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause <= pack_cause(1'b1, 1'b0, 1'b0, 1'b0);
        else if (rd)
            cause <= set_vec;
        else
            cause <= cause | set_vec;
    end
endmodule

// File: rtl/reset_supervisor.sv
// Reset and watchdog supervisor top. Merges the power-up hold, filtered pin,
// low-voltage flag and watchdog into one registered active-low core reset,
// records the causes, and presents the restart address. Assumes supply_ok is
// the block's own synchronous active-low reset.
module reset_supervisor #(
    parameter int unsigned     POR_CYCLES  = 1250000,
    parameter int unsigned     WDT_CYCLES  = 600000,
    parameter int unsigned     WDT_PULSE   = 16,
    parameter int unsigned     PIN_MIN_LOW = 5,
    parameter int unsigned     SYNC_STAGES = 2,
    parameter int unsigned     ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = 16'h000C
) (
    input  logic                             clk,
    input  logic                             ext_rst_n,
    input  logic                             supply_ok,
    input  logic                             lowv_flag,
    input  logic                             wd_kick,
    input  logic                             cause_rd,
    output logic                             sys_rst_n,
    output logic [rst_sup_pkg::CAUSE_W-1:0]  reset_cause,
    output logic [ADDR_W-1:0]                boot_addr
);
    import rst_sup_pkg::*;

    logic       por_done;
    logic       pin_accept;
    logic       lowv_q;
    logic       bite;
    logic       src_active;
    logic       rst_q;
    cause_vec_t set_vec;

    rst_por_delay #(.DELAY(POR_CYCLES)) u_por (
        .clk   (clk),
        .rst_n (supply_ok),
        .done  (por_done)
    );

    rst_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .MIN_LOW(PIN_MIN_LOW)) u_pin (
        .clk    (clk),
        .rst_n  (supply_ok),
        .pin_n  (ext_rst_n),
        .accept (pin_accept)
    );

    rst_watchdog #(.TIMEOUT(WDT_CYCLES), .PULSE(WDT_PULSE)) u_wdog (
        .clk           (clk),
        .rst_n         (supply_ok),
        .src_hold      (src_active),
        .core_in_reset (!rst_q),
        .kick          (wd_kick),
        .bite          (bite)
    );

    rst_cause_log u_cause (
        .clk     (clk),
        .rst_n   (supply_ok),
        .set_vec (set_vec),
        .rd      (cause_rd),
        .cause   (reset_cause)
    );

    assign src_active = !por_done || pin_accept || lowv_q;
    assign set_vec    = pack_cause(!por_done, pin_accept, lowv_q, bite);
    assign sys_rst_n  = rst_q;
    assign boot_addr  = BOOT_ADDR;

    // Register the low-voltage flag once to keep it off the output path.
    always_ff @(posedge clk) begin
        if (!supply_ok)
            lowv_q <= 1'b0;
        else
            lowv_q <= lowv_flag;
    end

    // Release the core only on an edge where no source is active.
    always_ff @(posedge clk) begin
        if (!supply_ok)
            rst_q <= 1'b0;
        else
            rst_q <= !(src_active || bite);
    end

    // R6
    lowv_fast_chk: assert property (@(posedge clk) disable iff (!supply_ok)
        lowv_flag |-> ##2 !sys_rst_n);

    // R2
    run_after_por_chk: assert property (@(posedge clk) disable iff (!supply_ok)
        sys_rst_n |-> por_done);

    // R9
    cause_on_reset_chk: assert property (@(posedge clk) disable iff (!supply_ok)
        $fell(sys_rst_n) |-> (reset_cause != '0));
endmodule

// File: tb/test_reset_supervisor.sv
module test_reset_supervisor;
    localparam int unsigned POR = 40;
    localparam int unsigned WDT = 30;
    localparam int unsigned PUL = 6;
    localparam int unsigned PMIN = 5;
    localparam int unsigned SYN = 2;

    logic       clk = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       supply_ok = 1'b0;
    logic       lowv_flag = 1'b0;
    logic       wd_kick = 1'b0;
    logic       cause_rd = 1'b0;
    logic       sys_rst_n;
    logic [3:0] reset_cause;
    logic [15:0] boot_addr;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          auto_kick = 1'b0;
    int unsigned since_kick = 0;
    int unsigned kick_gap = 1;

    reset_supervisor #(
        .POR_CYCLES(POR), .WDT_CYCLES(WDT), .WDT_PULSE(PUL),
        .PIN_MIN_LOW(PMIN), .SYNC_STAGES(SYN)
    ) i_reset_supervisor (
        .clk(clk), .ext_rst_n(ext_rst_n), .supply_ok(supply_ok),
        .lowv_flag(lowv_flag), .wd_kick(wd_kick), .cause_rd(cause_rd),
        .sys_rst_n(sys_rst_n), .reset_cause(reset_cause), .boot_addr(boot_addr)
    );

    always #10 clk = ~clk;

    function automatic logic [3:0] exp_cause(input bit por, input bit pin,
                                             input bit lowv, input bit wdog);
        return {wdog, lowv, pin, por};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // One clock: optional random refresh, then sample 1 ns after the edge.
    task automatic tick();
        if (auto_kick) begin
            if (since_kick >= kick_gap) begin
                wd_kick    = 1'b1;
                since_kick = 0;
                kick_gap   = $urandom_range(WDT - 1, 1);
            end else begin
                wd_kick = 1'b0;
                since_kick++;
            end
        end
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int unsigned n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic read_cause();
        cause_rd = 1'b1;
        tick();
        cause_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        report();
    end

    initial begin
        bit alive;
        void'($urandom(32'd1234));
        // R1, R10: power-down state
        ticks(3);
        chk("R1 rst low", sys_rst_n, 1'b0);
        chk("R1 cause", reset_cause, exp_cause(1, 0, 0, 0));
        chk("R10 boot addr", boot_addr, 16'h000C);

        // R2: power-up hold length
        supply_ok  = 1'b1;
        auto_kick  = 1'b1;
        since_kick = 0;
        ticks(POR);
        chk("R2 still held", sys_rst_n, 1'b0);
        tick();
        chk("R2 released", sys_rst_n, 1'b1);
        chk("R9 por cause", reset_cause, exp_cause(1, 0, 0, 0));
        read_cause();
        chk("R9 read clears", reset_cause, 4'h0);

        // R4, R7: random short glitches with random timely refreshes
        alive = 1'b1;
        for (int g = 0; g < 25; g++) begin
            ext_rst_n = 1'b0;
            for (int k = 0; k < $urandom_range(PMIN - 1, 1); k++) begin
                tick();
                if (sys_rst_n !== 1'b1) alive = 1'b0;
            end
            ext_rst_n = 1'b1;
            for (int k = 0; k < $urandom_range(8, 1); k++) begin
                tick();
                if (sys_rst_n !== 1'b1) alive = 1'b0;
            end
        end
        ticks(4);
        chk("R4 R7 no reset under glitches and kicks", alive, 1'b1);
        chk("R4 no cause", reset_cause, 4'h0);

        // R4: run one sample short
        ext_rst_n = 1'b0;
        ticks(PMIN - 1);
        ext_rst_n = 1'b1;
        ticks(10);
        chk("R4 short run ignored", sys_rst_n, 1'b1);
        chk("R4 short run cause", reset_cause, 4'h0);

        // R3: exact minimum run accepted
        ext_rst_n = 1'b0;
        ticks(PMIN);
        ext_rst_n = 1'b1;
        ticks(SYN + 1);
        chk("R3 exact run accepted", sys_rst_n, 1'b0);
        tick();
        chk("R5 short accept releases", sys_rst_n, 1'b1);
        chk("R9 pin cause", reset_cause, exp_cause(0, 1, 0, 0));
        read_cause();

        // R3, R5: assertion and release latency
        ext_rst_n = 1'b0;
        ticks(PMIN + SYN);
        chk("R3 not yet", sys_rst_n, 1'b1);
        tick();
        chk("R3 asserted", sys_rst_n, 1'b0);
        ticks(2);
        ext_rst_n = 1'b1;
        ticks(SYN + 1);
        chk("R5 still held", sys_rst_n, 1'b0);
        tick();
        chk("R5 released", sys_rst_n, 1'b1);
        read_cause();

        // R6: low-voltage latency and release
        lowv_flag = 1'b1;
        tick();
        chk("R6 one edge", sys_rst_n, 1'b1);
        tick();
        chk("R6 two edges", sys_rst_n, 1'b0);
        ticks(5);
        chk("R6 held", sys_rst_n, 1'b0);
        lowv_flag = 1'b0;
        tick();
        chk("R6 release pending", sys_rst_n, 1'b0);
        tick();
        chk("R6 released", sys_rst_n, 1'b1);
        chk("R9 lowv cause", reset_cause, exp_cause(0, 0, 1, 0));
        read_cause();

        // R11: overlap of low voltage and pin
        lowv_flag = 1'b1;
        ticks(2);
        ext_rst_n = 1'b0;
        ticks(10);
        lowv_flag = 1'b0;
        ticks(4);
        chk("R11 pin still holds", sys_rst_n, 1'b0);
        ext_rst_n = 1'b1;
        ticks(SYN + 1);
        chk("R11 last source", sys_rst_n, 1'b0);
        tick();
        chk("R11 released", sys_rst_n, 1'b1);
        chk("R9 two causes", reset_cause, exp_cause(0, 1, 1, 0));
        read_cause();
        chk("R9 cleared", reset_cause, 4'h0);

        // R7, R8: watchdog limit, bite and pulse length
        auto_kick = 1'b0;
        wd_kick   = 1'b1;
        tick();
        wd_kick = 1'b0;
        ticks(WDT - 1);
        wd_kick = 1'b1;
        tick();
        wd_kick = 1'b0;
        chk("R7 kick at limit", sys_rst_n, 1'b1);
        ticks(WDT);
        chk("R7 before bite", sys_rst_n, 1'b1);
        tick();
        chk("R7 bite", sys_rst_n, 1'b0);
        ticks(PUL - 1);
        chk("R8 pulse held", sys_rst_n, 1'b0);
        tick();
        chk("R8 pulse ended", sys_rst_n, 1'b1);
        auto_kick  = 1'b1;
        since_kick = 0;
        chk("R9 wdog cause", reset_cause, exp_cause(0, 0, 0, 1));
        read_cause();
        ticks(3 * WDT);
        chk("R7 running after bite", sys_rst_n, 1'b1);

        // R1: power loss
        supply_ok = 1'b0;
        tick();
        chk("R1 power loss", sys_rst_n, 1'b0);
        chk("R1 power loss cause", reset_cause, exp_cause(1, 0, 0, 0));

        report();
    end
endmodule